// File: doc/BRIEF.md
# Link lane and rate selector

This block works out how a display main link should be configured for a given video stream, and how to fall back to a lower configuration when link training fails. From the pixel clock in kHz and the bits per colour component it derives the stream payload in kB/s. It then chooses the highest link-rate code the sink offers and the smallest lane count from the set 1, 2, 4 whose capacity covers that payload. If even the sink's widest link falls short, the lane count stops at the sink's maximum and a shortage flag is raised.

After a training failure the controller issues a downshift request. The block lowers the held rate by one step and, where the sink allows it, doubles the lane count. It then accepts the new configuration only if the new total capacity is strictly greater than the payload. A rejected proposal leaves the held configuration unchanged and reports the failure.

Both operations run as a short multi-cycle sequence behind a start/done handshake. The chosen configuration stays on the outputs until the next accepted operation changes it.

Top module: `link_cfg_sel`

## Requirements
- R1: After reset, rate_code is 0, lane_cnt is 0, and busy, done, bw_short and shift_ok are all 0.
- R2: The payload is floor(pclk_khz * 3 * bpc / 8), computed in 32-bit unsigned arithmetic. The fraction is dropped before any capacity comparison.
- R3: An initial selection (op = 0) sets rate_code to max_rate. The per-lane capacity is floor(270000 * rate_code / 10). lane_cnt becomes the smallest of 1, 2, 4 whose lanes * per-lane capacity is greater than or equal to the payload.
- R4: If no lane count up to max_lanes meets R3, the initial selection sets lane_cnt to max_lanes and bw_short to 1. When R3 is met, bw_short is 0.
- R5: A downshift (op = 1) is possible only when the held rate_code is greater than 0x06 and at most 0x0A. The proposed rate is the held rate minus 4. Any other held rate makes the downshift fail.
- R6: A downshift proposes twice the held lane count when the held lane count is at least 1 and below max_lanes. Otherwise it proposes the held lane count.
- R7: A downshift is accepted only if proposed lanes * per-lane capacity at the proposed rate is strictly greater than the payload. On acceptance, rate_code and lane_cnt take the proposal and shift_ok is 1. On rejection, rate_code and lane_cnt keep their values and shift_ok is 0.
- R8: A start seen while busy is 0 begins an operation. busy then stays 1 until the operation ends. done is a single-cycle pulse that marks the end of the operation. A start seen while busy is 1 is ignored.
- R9: lane_cnt only ever holds 0, 1, 2 or 4.
- R10: An initial selection clears shift_ok. An accepted downshift clears bw_short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| op | input | 1 | 0 = initial selection, 1 = downshift |
| pclk_khz | input | 32 | Pixel clock in kHz |
| bpc | input | 5 | Bits per colour component |
| max_lanes | input | 3 | Sink lane limit (1, 2 or 4) |
| max_rate | input | 8 | Sink maximum rate code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rate_code | output | 8 | Selected link-rate code |
| lane_cnt | output | 3 | Selected lane count |
| bw_short | output | 1 | Widest allowed link cannot carry the payload |
| shift_ok | output | 1 | Last downshift was accepted |

## Verification
A payload register that is computed wrongly, or rounded up instead of truncated, shows up as a different lane count in the same done cycle. The scenarios that sit exactly at a capacity boundary expose it. A faulty lane-search step appears at done either as a lane count one doubling off or as a wrong bw_short. A downshift that uses the wrong comparison or the wrong rate window is visible at its done pulse as a changed rate_code where the old one should have stayed, or the reverse. A start that leaks in while busy alters the configuration reported at the first done.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  parameter int ARITH_W   = 32;
  parameter int PCLK_W    = 32;
  parameter int BPC_W     = 5;
  parameter int RATE_W    = 8;
  parameter int LANE_W    = 3;
  parameter int LINK_UNIT = 270000;
  parameter int RATE_LO   = 6;
  parameter int RATE_HI   = 10;
  parameter int RATE_STEP = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_SRCH,
    ST_DOWN
  } lcs_state_t;

  // Stream payload in kB/s, 32-bit wrap, truncating divide by 8
  function automatic logic [ARITH_W-1:0] payload_kbs(
    input logic [PCLK_W-1:0] pclk,
    input logic [BPC_W-1:0]  bpc
  );
    logic [ARITH_W-1:0] bits;
    logic [ARITH_W-1:0] prod;
    bits = ARITH_W'(bpc) * ARITH_W'(3);
    prod = ARITH_W'(pclk) * bits;
    return prod >> 3;
  endfunction

  // Per-lane capacity in kB/s after line coding overhead
  function automatic logic [ARITH_W-1:0] lane_cap_kbs(
    input logic [RATE_W-1:0] rate
  );
    logic [ARITH_W-1:0] raw;
    raw = ARITH_W'(LINK_UNIT) * ARITH_W'(rate);
    return raw / ARITH_W'(10);
  endfunction
endpackage

// File: rtl/lcs_payload.sv
module lcs_payload
  import lcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PCLK_W-1:0]  pclk,
  input  logic [BPC_W-1:0]   bpc,
  output logic [ARITH_W-1:0] payload
);
  always_ff @(posedge clk) begin
    if (!rst_n) payload <= '0;
    else if (load) payload <= payload_kbs(pclk, bpc);
  end
endmodule

// File: rtl/lcs_cap.sv
module lcs_cap
  import lcs_pkg::*;
(
  input  logic [RATE_W-1:0]  rate,
  input  logic [LANE_W-1:0]  lanes,
  output logic [ARITH_W-1:0] total
);
  logic [ARITH_W-1:0] per_lane;
  always_comb begin
    per_lane = lane_cap_kbs(rate);
    total    = per_lane * ARITH_W'(lanes);
  end
endmodule

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
  import lcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op,
  input  logic [LANE_W-1:0]  max_lanes,
  input  logic [RATE_W-1:0]  max_rate,
  input  logic [ARITH_W-1:0] payload,
  input  logic [ARITH_W-1:0] cur_total,
  input  logic [ARITH_W-1:0] new_total,
  output logic               accept_start,
  output logic [RATE_W-1:0]  rate_q,
  output logic [LANE_W-1:0]  lane_q,
  output logic [RATE_W-1:0]  nrate,
  output logic [LANE_W-1:0]  nlane,
  output logic [LANE_W-1:0]  maxl_q,
  output logic               busy,
  output logic               done,
  output logic               bw_short,
  output logic               shift_ok,
  output logic               dn_eval,
  output logic               dn_accept
);
  localparam logic [RATE_W-1:0] R_LO   = RATE_W'(RATE_LO);
  localparam logic [RATE_W-1:0] R_HI   = RATE_W'(RATE_HI);
  localparam logic [RATE_W-1:0] R_STEP = RATE_W'(RATE_STEP);

  lcs_state_t        state;
  logic              op_q;
  logic [RATE_W-1:0] maxr_q;
  logic              in_window;
  logic [LANE_W:0]   lane_dbl;
  logic              covers;
  logic              no_wider;

  assign accept_start = start && (state == ST_IDLE);
  assign busy         = (state != ST_IDLE);
  assign dn_eval      = (state == ST_DOWN);

  always_comb begin
    in_window = (rate_q > R_LO) && (rate_q <= R_HI);
    nrate     = rate_q - R_STEP;
    nlane     = (lane_q >= LANE_W'(1) && lane_q < maxl_q) ? (lane_q << 1) : lane_q;
    dn_accept = in_window && (new_total > payload);
    lane_dbl  = {1'b0, lane_q} << 1;
    covers    = (cur_total >= payload);
    no_wider  = (lane_dbl > {1'b0, maxl_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= 1'b0;
      maxl_q   <= '0;
      maxr_q   <= '0;
      rate_q   <= '0;
      lane_q   <= '0;
      done     <= 1'b0;
      bw_short <= 1'b0;
      shift_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q   <= op;
            maxl_q <= max_lanes;
            maxr_q <= max_rate;
            state  <= ST_CALC;
          end
        end
        ST_CALC: begin
          if (!op_q) begin
            rate_q   <= maxr_q;
            lane_q   <= LANE_W'(1);
            shift_ok <= 1'b0;
            state    <= ST_SRCH;
          end else begin
            state <= ST_DOWN;
          end
        end
        ST_SRCH: begin
          if (covers) begin
            bw_short <= 1'b0;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else if (no_wider) begin
            lane_q   <= maxl_q;
            bw_short <= 1'b1;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            lane_q <= lane_dbl[LANE_W-1:0];
          end
        end
        ST_DOWN: begin
          if (dn_accept) begin
            rate_q   <= nrate;
            lane_q   <= nlane;
            bw_short <= 1'b0;
          end
          shift_ok <= dn_accept;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_cfg_sel.sv
module link_cfg_sel
  import lcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op,
  input  logic [PCLK_W-1:0]  pclk_khz,
  input  logic [BPC_W-1:0]   bpc,
  input  logic [LANE_W-1:0]  max_lanes,
  input  logic [RATE_W-1:0]  max_rate,
  output logic               busy,
  output logic               done,
  output logic [RATE_W-1:0]  rate_code,
  output logic [LANE_W-1:0]  lane_cnt,
  output logic               bw_short,
  output logic               shift_ok
);
  logic               accept_start;
  logic [ARITH_W-1:0] payload;
  logic [ARITH_W-1:0] cur_total;
  logic [ARITH_W-1:0] new_total;
  logic [RATE_W-1:0]  nrate;
  logic [LANE_W-1:0]  nlane;
  logic [LANE_W-1:0]  maxl_q;
  logic               dn_eval;
  logic               dn_accept;

  lcs_payload u_pay (
    .clk(clk), .rst_n(rst_n), .load(accept_start),
    .pclk(pclk_khz), .bpc(bpc), .payload(payload)
  );

  lcs_cap u_cap_cur (.rate(rate_code), .lanes(lane_cnt), .total(cur_total));
  lcs_cap u_cap_new (.rate(nrate), .lanes(nlane), .total(new_total));

  lcs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .max_lanes(max_lanes), .max_rate(max_rate), .payload(payload),
    .cur_total(cur_total), .new_total(new_total),
    .accept_start(accept_start), .rate_q(rate_code), .lane_q(lane_cnt),
    .nrate(nrate), .nlane(nlane), .maxl_q(maxl_q),
    .busy(busy), .done(done), .bw_short(bw_short), .shift_ok(shift_ok),
    .dn_eval(dn_eval), .dn_accept(dn_accept)
  );
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker
  import lcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [RATE_W-1:0] rate_code,
  input logic [LANE_W-1:0] lane_cnt,
  input logic              bw_short,
  input logic              shift_ok,
  input logic [LANE_W-1:0] maxl_q,
  input logic              dn_eval,
  input logic              dn_accept
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r9_lane_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_cnt) <= 1);

  a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_eval && !dn_accept) |=> ($stable(rate_code) && $stable(lane_cnt) && !shift_ok));

  a_r5_rate_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_eval && dn_accept) |=> (rate_code == $past(rate_code) - RATE_W'(RATE_STEP)) && shift_ok);

  a_r4_short_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bw_short && !shift_ok) |-> (lane_cnt == maxl_q));
endmodule

bind link_cfg_sel lcs_checker u_lcs_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rate_code(rate_code), .lane_cnt(lane_cnt), .bw_short(bw_short),
  .shift_ok(shift_ok), .maxl_q(maxl_q), .dn_eval(dn_eval), .dn_accept(dn_accept)
);

// File: tb/tb_link_cfg_sel.sv
module tb_link_cfg_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [31:0] pclk_khz = '0;
  logic [4:0]  bpc = '0;
  logic [2:0]  max_lanes = '0;
  logic [7:0]  max_rate = '0;
  logic        busy, done, bw_short, shift_ok;
  logic [7:0]  rate_code;
  logic [2:0]  lane_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit wd_hit = 0;

  always #4 clk = ~clk;

  link_cfg_sel dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pclk_khz(pclk_khz),
    .bpc(bpc), .max_lanes(max_lanes), .max_rate(max_rate), .busy(busy),
    .done(done), .rate_code(rate_code), .lane_cnt(lane_cnt),
    .bw_short(bw_short), .shift_ok(shift_ok)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_pay(input longint pk, input longint b);
    return ((pk * b * 3) & 64'hFFFF_FFFF) / 8;
  endfunction

  function automatic longint ref_cap(input longint r);
    return (r * 27000);
  endfunction

  task automatic launch(input bit o, input int pk, input int b, input int ml, input int mr);
    @(negedge clk);
    op = o; pclk_khz = pk; bpc = b[4:0]; max_lanes = ml[2:0]; max_rate = mr[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R8 actual=no_done expected=done");
    end
  endtask

  task automatic t_init(input string tag, input int pk, input int b, input int ml, input int mr);
    longint pay, l;
    bit shrt;
    launch(1'b0, pk, b, ml, mr);
    wait_done();
    pay = ref_pay(pk, b);
    l = 1; shrt = 0;
    forever begin
      if (l * ref_cap(mr) >= pay) break;
      if (l * 2 > ml) begin shrt = 1; l = ml; break; end
      l = l * 2;
    end
    chk({tag, " R3 rate"}, rate_code, mr);
    chk({tag, " R3 lanes"}, lane_cnt, l);
    chk({tag, " R4 bw_short"}, bw_short, shrt);
    chk({tag, " R10 shift_ok cleared"}, shift_ok, 0);
  endtask

  task automatic t_down(input string tag, input int pk, input int b, input int ml);
    longint r0, l0, nr, nl, pay;
    bit ok;
    r0 = rate_code; l0 = lane_cnt;
    launch(1'b1, pk, b, ml, 0);
    wait_done();
    pay = ref_pay(pk, b);
    ok = (r0 > 6) && (r0 <= 10);
    nr = r0 - 4;
    nl = (l0 >= 1 && l0 < ml) ? l0 * 2 : l0;
    ok = ok && (ref_cap(nr) * nl > pay);
    chk({tag, " R7 shift_ok"}, shift_ok, ok);
    chk({tag, " R5 rate"}, rate_code, ok ? nr : r0);
    chk({tag, " R6 lanes"}, lane_cnt, ok ? nl : l0);
    if (ok) chk({tag, " R10 bw_short cleared"}, bw_short, 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    wd_hit = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rate", rate_code, 0);
    chk("R1 lanes", lane_cnt, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 flags", {bw_short, shift_ok}, 0);
    rst_n = 1'b1;
    t_down("reset_down R5", 148500, 8, 4);
    // R3: two lanes at top rate, then accepted downshift to four lanes
    t_init("fhd", 148500, 8, 4, 10);
    chk("fhd R3 lanes value", lane_cnt, 2);
    t_down("fhd_down", 148500, 8, 4);
    chk("fhd_down R5 rate value", rate_code, 6);
    t_down("at_floor R5", 148500, 8, 4);
    // four lanes, downshift rejected at lane limit
    t_init("wide", 268500, 8, 4, 10);
    t_down("wide_down R7", 268500, 8, 4);
    chk("wide_down R7 kept rate", rate_code, 10);
    // R4 shortage with two-lane sink
    t_init("short2", 268500, 8, 2, 10);
    chk("short2 R4 flag", bw_short, 1);
    t_init("short1", 108000, 8, 1, 10);
    // R7 equality rejected
    t_init("eq", 108000, 8, 2, 10);
    t_down("eq_down R7", 108000, 8, 2);
    chk("eq_down R7 strict", shift_ok, 0);
    // R3 equality accepted at initial selection
    t_init("eq_init", 90000, 8, 4, 10);
    chk("eq_init R3 one lane", lane_cnt, 1);
    // R2 truncation: payload 27000.75 floors to 27000, fits one lane
    t_init("trunc R2", 10286, 7, 4, 1);
    chk("trunc R2 one lane", lane_cnt, 1);
    // R5 rate above window
    t_init("hi", 268500, 8, 4, 20);
    t_down("hi_down R5", 268500, 8, 4);
    // R8 start while busy ignored
    @(negedge clk);
    op = 0; pclk_khz = 148500; bpc = 8; max_lanes = 4; max_rate = 10; start = 1;
    @(negedge clk);
    chk("R8 busy", busy, 1);
    pclk_khz = 268500; max_rate = 6;
    @(negedge clk);
    start = 0;
    wait_done();
    chk("R8 ignored rate", rate_code, 10);
    chk("R8 ignored lanes", lane_cnt, 2);
    @(negedge clk);
    chk("R8 done single", done, 0);
    repeat (8) @(negedge clk);
    chk("R8 no extra op", busy, 0);
    chk("R9 lanes legal", (lane_cnt == 0 || lane_cnt == 1 || lane_cnt == 2 || lane_cnt == 4), 1);
    if (wd_hit) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (wd_hit);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule